// File: doc/BRIEF.md
# LIN Break Detector

This block sits next to an asynchronous serial receiver and decides whether a LIN break has arrived on the receive line. It keeps its own view of the line and does not depend on the data deserialiser. As a result it can pick up a break while the line is idle and also in the middle of a data frame. Every bit is judged on a 16x oversampling tick. The block looks for a falling edge, then takes a majority vote over three mid-bit samples of each bit. It counts consecutive low bits. When the count reaches the selected break length and a high bit follows, it raises a sticky flag.

The flag drives an interrupt output through an enable. A hold output stalls the data receiver after that receiver reports a framing error. The hold is released once the detector resolves the event by seeing a high bit. That high bit ends either an incomplete attempt or a confirmed break. When LIN mode or the receiver is switched off, the detector stays idle and never stalls the receiver.

Top module: `lin_brk_det`

## Requirements
- R1: The detector is active only while `lin_en_i` and `rx_en_i` are both high. While inactive it never sets the flag, and `rx_hold_o` is low in the cycle after any inactive cycle.
- R2: Sample 1 of a bit is the tick on which the line is first seen low after being high. Bit boundaries follow every 16 ticks from there. A bit's value is the majority of the line on ticks 8, 9 and 10 of that bit, so one deviating sample among the three does not change the bit.
- R3: An attempt starts only on a falling edge, and its first bit must vote low. A low pulse whose vote is high is dropped and adds nothing to a later count.
- R4: The run of low bits needed is 10 when `long_brk_i` is 0 and 11 when it is 1. The run includes the first bit of the attempt.
- R5: A high bit voted before the required count is reached abandons the attempt. A new search begins at the next falling edge.
- R6: Once the count is reached, the flag rises only on the tick of sample 10 of the first bit that votes high. It stays low while the line remains low, however long that lasts.
- R7: `brk_flag_o` stays set until `flag_clr_i` is high for a cycle. If a set and a clear fall in the same cycle, the flag ends set.
- R8: `irq_o` is high exactly when `brk_flag_o` and `irq_en_i` are both high.
- R9: While the detector is active, a `frame_err_i` pulse raises `rx_hold_o`. The hold falls after the detector votes a high bit, either one that ends an attempt or the break delimiter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Synchronised receive line |
| tick_i | input | 1 | 16x oversampling strobe, one cycle wide |
| rx_en_i | input | 1 | Receiver enable |
| lin_en_i | input | 1 | LIN mode enable |
| long_brk_i | input | 1 | Break length: 0 means 10 bits, 1 means 11 bits |
| frame_err_i | input | 1 | Framing error pulse from the data receiver |
| irq_en_i | input | 1 | Break interrupt enable |
| flag_clr_i | input | 1 | Clears the break flag |
| brk_flag_o | output | 1 | Sticky break flag |
| irq_o | output | 1 | Break interrupt |
| rx_hold_o | output | 1 | Stall request to the data receiver |

## Verification
The bench builds the block with its default parameters: 16 samples per bit, votes on samples 8 to 10, and break lengths of 10 and 11. With a tick every second clock, a whole break plus its delimiter takes a few hundred cycles. That leaves room for about forty random line patterns with mixed low runs, plus directed cases. The directed cases cover the exact-length boundary for both settings, single-sample glitches, a short start pulse, set against clear in one cycle, and the release of the hold.

// File: rtl/lbd_pkg.sv
package lbd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_DELIM = 2'd2
  } lbd_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/lbd_bit_sampler.sv
module lbd_bit_sampler
  import lbd_pkg::*;
#(
  parameter int OVS = 16,
  parameter int MID = 9   // 0-based index of the last vote sample
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic start_i,
  input  logic tick_i,
  input  logic rx_i,
  output logic bit_vld_o,
  output logic bit_val_o
);
  localparam int PH_W = $clog2(OVS);
  localparam logic [PH_W-1:0] PH_A    = PH_W'(MID - 2);
  localparam logic [PH_W-1:0] PH_B    = PH_W'(MID - 1);
  localparam logic [PH_W-1:0] PH_C    = PH_W'(MID);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);

  logic [PH_W-1:0] phase_q, ph_nxt;
  logic            smp_a_q, smp_b_q;

  assign ph_nxt = (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      smp_a_q <= 1'b1;
      smp_b_q <= 1'b1;
    end else if (start_i) begin
      phase_q <= '0;  // edge tick is sample 1
    end else if (run_i && tick_i) begin
      phase_q <= ph_nxt;
      if (ph_nxt == PH_A) smp_a_q <= rx_i;
      if (ph_nxt == PH_B) smp_b_q <= rx_i;
    end
  end

  assign bit_vld_o = run_i & tick_i & ~start_i & (ph_nxt == PH_C);
  assign bit_val_o = maj3(smp_a_q, smp_b_q, rx_i);
endmodule

// File: rtl/lbd_run_ctr.sv
module lbd_run_ctr #(
  parameter int LEN_SHORT = 10,
  parameter int LEN_LONG  = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  input  logic long_i,
  output logic reach_o
);
  localparam int CNT_W = $clog2(LEN_LONG + 1);
  localparam logic [CNT_W-1:0] TGT_S = CNT_W'(LEN_SHORT);
  localparam logic [CNT_W-1:0] TGT_L = CNT_W'(LEN_LONG);

  logic [CNT_W-1:0] cnt_q, cnt_inc, target;

  assign target  = long_i ? TGT_L : TGT_S;
  assign cnt_inc = (cnt_q == TGT_L) ? cnt_q : cnt_q + 1'b1;
  assign reach_o = inc_i & (cnt_inc >= target);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_inc;
  end
endmodule

// File: rtl/lbd_flag_ctl.sv
module lbd_flag_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en_i,
  input  logic ferr_i,
  input  logic hi_seen_i,
  output logic flag_o,
  output logic irq_o,
  output logic hold_o
);
  logic flag_q, hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;  // set beats clear
    else if (clr_i)  flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hold_q <= 1'b0;
    else if (!active_i)  hold_q <= 1'b0;
    else if (ferr_i)     hold_q <= 1'b1;
    else if (hi_seen_i)  hold_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;
  assign hold_o = hold_q;
endmodule

// File: rtl/lin_brk_det.sv
module lin_brk_det
  import lbd_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int VOTE_MID  = 9,
  parameter int LEN_SHORT = 10,
  parameter int LEN_LONG  = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic tick_i,
  input  logic rx_en_i,
  input  logic lin_en_i,
  input  logic long_brk_i,
  input  logic frame_err_i,
  input  logic irq_en_i,
  input  logic flag_clr_i,
  output logic brk_flag_o,
  output logic irq_o,
  output logic rx_hold_o
);
  lbd_state_e state_q, state_d;
  logic active, prev_q, start, bit_vld, bit_val;
  logic inc, reach, set_flag, hi_seen, in_idle;

  assign active  = lin_en_i & rx_en_i;
  assign in_idle = (state_q == ST_IDLE);
  assign start   = active & in_idle & tick_i & ~rx_i & prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 prev_q <= 1'b1;
    else if (!active)            prev_q <= 1'b1;
    else if (tick_i)             prev_q <= rx_i;
  end

  lbd_bit_sampler #(.OVS(OVS), .MID(VOTE_MID)) u_smp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (active & ~in_idle),
    .start_i  (start),
    .tick_i   (tick_i),
    .rx_i     (rx_i),
    .bit_vld_o(bit_vld),
    .bit_val_o(bit_val)
  );

  assign inc = (state_q == ST_COUNT) & bit_vld & ~bit_val;

  lbd_run_ctr #(.LEN_SHORT(LEN_SHORT), .LEN_LONG(LEN_LONG)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (in_idle | ~active),
    .inc_i  (inc),
    .long_i (long_brk_i),
    .reach_o(reach)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_COUNT;
      ST_COUNT: if (bit_vld) state_d = bit_val ? ST_IDLE : (reach ? ST_DELIM : ST_COUNT);
      ST_DELIM: if (bit_vld && bit_val) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    if (!active) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign set_flag = active & (state_q == ST_DELIM) & bit_vld & bit_val;
  assign hi_seen  = (~in_idle & bit_vld & bit_val) | (in_idle & tick_i & rx_i);

  lbd_flag_ctl u_flg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .set_i    (set_flag),
    .clr_i    (flag_clr_i),
    .irq_en_i (irq_en_i),
    .ferr_i   (frame_err_i),
    .hi_seen_i(hi_seen),
    .flag_o   (brk_flag_o),
    .irq_o    (irq_o),
    .hold_o   (rx_hold_o)
  );
endmodule

// File: rtl/lin_brk_det_chk.sv
module lin_brk_det_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic rx_en_i,
  input logic lin_en_i,
  input logic irq_en_i,
  input logic flag_clr_i,
  input logic brk_flag_o,
  input logic irq_o,
  input logic rx_hold_o
);
  // R1
  flag_rise_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_flag_o) |-> $past(lin_en_i && rx_en_i));

  // R1
  hold_idle_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lin_en_i && rx_en_i) |=> !rx_hold_o);

  // R6
  flag_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_flag_o) |-> $past(tick_i));

  // R7
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_flag_o && !flag_clr_i |=> brk_flag_o);

  // R8
  irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (brk_flag_o && irq_en_i));
endmodule

bind lin_brk_det lin_brk_det_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .rx_en_i   (rx_en_i),
  .lin_en_i  (lin_en_i),
  .irq_en_i  (irq_en_i),
  .flag_clr_i(flag_clr_i),
  .brk_flag_o(brk_flag_o),
  .irq_o     (irq_o),
  .rx_hold_o (rx_hold_o)
);

// File: tb/lin_brk_det_tb.sv
module lin_brk_det_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic rx = 1'b1, tick = 1'b0, rx_en = 1'b0, lin_en = 1'b0, long_brk = 1'b0;
  logic ferr = 1'b0, irq_en = 1'b0, clr = 1'b0;
  logic flag, irq, hold;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  lin_brk_det u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_i(rx), .tick_i(tick), .rx_en_i(rx_en),
    .lin_en_i(lin_en), .long_brk_i(long_brk), .frame_err_i(ferr),
    .irq_en_i(irq_en), .flag_clr_i(clr), .brk_flag_o(flag), .irq_o(irq),
    .rx_hold_o(hold)
  );

  function automatic bit exp_brk(int run, bit lng, bit en);
    return en && (run >= (lng ? 11 : 10));
  endfunction

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one oversampling tick over two clocks
  task automatic do_tick(input logic v, input logic c);
    @(negedge clk); rx = v; tick = 1'b1; clr = c;
    @(negedge clk); tick = 1'b0; clr = 1'b0;
  endtask

  task automatic send_bit(input logic v, input logic [15:0] msk);
    for (int k = 0; k < 16; k++) do_tick(v ^ msk[k], 1'b0);
  endtask

  task automatic send_run(input logic v, input int n);
    for (int i = 0; i < n; i++) send_bit(v, 16'h0);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic pulse_ferr();
    @(negedge clk); ferr = 1'b1;
    @(negedge clk); ferr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(flag, 0, "R7 reset flag");
    chk(hold, 0, "R9 reset hold");
    chk(irq, 0, "R8 reset irq");
    rst_ni = 1'b1;

    // R1: inactive detector
    rx_en = 1'b1; lin_en = 1'b0;
    send_run(1, 2); send_run(0, 14); pulse_ferr(); send_run(1, 2);
    chk(flag, 0, "R1 lin off no flag");
    chk(hold, 0, "R1 lin off no hold");
    lin_en = 1'b1; rx_en = 1'b0;
    send_run(0, 14); send_run(1, 2);
    chk(flag, 0, "R1 rx off no flag");
    rx_en = 1'b1; irq_en = 1'b1;

    // R4: boundaries
    long_brk = 1'b0; send_run(0, 9); send_run(1, 2);
    chk(flag, 0, "R4 nine lows short");
    send_run(0, 10); send_run(1, 2);
    chk(flag, 1, "R4 ten lows short");
    chk(irq, 1, "R8 irq with enable");
    irq_en = 1'b0; @(negedge clk);
    chk(irq, 0, "R8 irq gated");
    pulse_clr(); chk(flag, 0, "R7 clear");
    long_brk = 1'b1; send_run(0, 10); send_run(1, 2);
    chk(flag, 0, "R4 ten lows long");
    send_run(0, 11); send_run(1, 2);
    chk(flag, 1, "R4 eleven lows long");
    pulse_clr(); long_brk = 1'b0;

    // R6: delimiter timing and long low line
    send_run(0, 20);
    chk(flag, 0, "R6 no flag while low");
    for (int k = 0; k < 9; k++) do_tick(1'b1, 1'b0);
    chk(flag, 0, "R6 before sample 10");
    do_tick(1'b1, 1'b0);
    chk(flag, 1, "R6 at sample 10");
    send_run(1, 1); pulse_clr();

    // R7: set and clear in the same cycle
    send_run(0, 10);
    for (int k = 0; k < 9; k++) do_tick(1'b1, 1'b0);
    do_tick(1'b1, 1'b1);
    chk(flag, 1, "R7 set wins");
    send_run(1, 1); pulse_clr();
    chk(flag, 0, "R7 clear after");

    // R2: single sample glitch at sample 9 ignored
    send_run(0, 4); send_bit(0, 16'h0100); send_run(0, 5); send_run(1, 2);
    chk(flag, 1, "R2 one bad sample");
    pulse_clr();
    // R2: samples 8 and 9 high make the bit high, abort
    send_run(0, 4); send_bit(0, 16'h0180); send_run(1, 1); send_run(0, 6); send_run(1, 2);
    chk(flag, 0, "R2 two bad samples");

    // R3: short low pulse rejected, next run of 9 not enough
    send_bit(1, 16'h000F); send_run(0, 9); send_run(1, 2);
    chk(flag, 0, "R3 short start pulse");

    // R5: abort and restart
    send_run(0, 6); send_run(1, 1); send_run(0, 6); send_run(1, 2);
    chk(flag, 0, "R5 high aborts");
    send_run(0, 10); send_run(1, 2);
    chk(flag, 1, "R5 restart finds break");
    pulse_clr();

    // R9: hold after framing error
    send_run(0, 5); pulse_ferr();
    chk(hold, 1, "R9 hold set");
    send_run(0, 7);
    chk(hold, 1, "R9 hold while low");
    send_bit(1, 16'h0);
    chk(hold, 0, "R9 released by delimiter");
    chk(flag, 1, "R9 break confirmed");
    pulse_clr();
    send_run(0, 4); pulse_ferr(); send_bit(1, 16'h0);
    chk(hold, 0, "R9 released by high bit");

    // random line patterns
    for (int s = 0; s < 40; s++) begin
      bit lng, en, ie, exp;
      lng = 1'($urandom_range(0, 1));
      en  = ($urandom_range(0, 7) != 0);
      ie  = 1'($urandom_range(0, 1));
      long_brk = lng; lin_en = en; irq_en = ie; exp = 1'b0;
      send_run(1, 2);
      for (int g = 0; g < 3; g++) begin
        int lo, hi;
        lo = $urandom_range(1, 14);
        hi = $urandom_range(1, 3);
        send_run(0, lo); send_run(1, hi);
        exp |= exp_brk(lo, lng, en);
      end
      chk(flag, int'(exp), "R4 random pattern");
      chk(irq, int'(exp && ie), "R8 random irq");
      pulse_clr(); lin_en = 1'b1;
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule